// File: doc/BRIEF.md
# Smart-Card Serial Transceiver with Parity Error Signaling

This block is a full-duplex asynchronous transceiver for a smart-card style link. On that link the transmit and receive pins are tied together outside the chip, so both ends share one open-drain line. Each character is framed as a low start bit, eight data bits sent least significant first, a parity bit and a high stop bit. The bit time comes from a programmable divider. The divider runs on one of three prescaled versions of the system clock or on an external tick.

The transmitter holds one byte in a buffer and one in a shift register. It reports buffer-empty and shift-register-empty separately, and it raises an interrupt request on either buffer transfer or frame completion, as the caller selects. The receiver oversamples the line 16 times per bit. It places each completed byte in a receive buffer and flags completion until that buffer is read.

When a received parity bit is wrong, the receiver pulls its own transmit output low for one full bit time, starting at the stop-bit slot. The far end therefore sees a low level where a high stop bit belongs. In the same way, the transmitter latches the line level at the middle of its own stop bit, so a card that rejects a character can be detected.

Top module: `sc_uart`

## Requirements
- R1: After reset, `txd_o` is 1, `txbuf_empty_o` and `txreg_empty_o` are 1, and `rx_full_o`, `rx_perr_o`, `tx_err_seen_o`, `tx_irq_o` and `rx_irq_o` are 0.
- R2: A transmitted frame is one start bit of 0, then data bits D0 to D7 with D0 first, then one parity bit, then one stop bit of 1.
- R3: The parity bit equals the XOR of the eight data bits when `par_odd_i` is 0 (even parity), and its inverse when `par_odd_i` is 1 (odd parity). The receiver checks against the same rule.
- R4: One bit lasts exactly 16 × (`div_i` + 1) × P clock cycles. P is 1, 2 or 8 for `clk_sel_i` values 0, 1 or 2. Value 3 counts rising edges of `ext_tick_i` instead.
- R5: `txbuf_empty_o` is 0 in the cycle after `tx_wr_i`. It returns to 1 when the byte moves into the shift register, which is also the moment the start bit begins.
- R6: `txreg_empty_o` is 0 while a frame is being shifted out and 1 once its stop bit has ended. `txd_o` is 1 whenever the transmitter is idle and no error pulse is being driven.
- R7: With `tx_irq_sel_i` = 0, `tx_irq_o` sets when the buffer transfers into the shift register. With `tx_irq_sel_i` = 1, it sets only when the frame completes.
- R8: `tx_irq_o` and `rx_irq_o` each stay at 1 until their clear input is asserted.
- R9: While `tx_en_i` is 0, no frame starts. A written byte waits in the buffer, and it goes out once `tx_en_i` becomes 1.
- R10: After a frame is received with `rx_en_i` = 1, `rx_full_o` and `rx_irq_o` set and `rx_data_o` holds the byte. A one-cycle `rx_rd_i` clears `rx_full_o`.
- R11: A frame that arrives while `rx_en_i` is 0 leaves `rx_full_o` at 0.
- R12: On a parity mismatch, `rx_perr_o` is 1 with the delivered byte, and `txd_o` is driven low for one bit time starting at the stop-bit slot. On a good frame, `rx_perr_o` is 0 and `txd_o` stays high.
- R13: `tx_err_seen_o` takes the inverse of the line level at the middle of the transmitter's own stop bit. It is 1 when the far end held the line low there, and 0 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| clk_sel_i | input | 2 | Count clock select: /1, /2, /8, external tick |
| ext_tick_i | input | 1 | External count clock, counted on rising edges |
| div_i | input | DIV_W | Divider value n |
| tx_en_i | input | 1 | Transmit enable |
| rx_en_i | input | 1 | Receive enable |
| par_odd_i | input | 1 | 1 selects odd parity, 0 even parity |
| tx_irq_sel_i | input | 1 | Transmit interrupt cause: 0 buffer transfer, 1 frame done |
| tx_wr_i | input | 1 | Write strobe for the transmit buffer |
| tx_data_i | input | 8 | Byte to transmit |
| rx_rd_i | input | 1 | Read strobe for the receive buffer |
| rx_data_o | output | 8 | Received byte |
| txbuf_empty_o | output | 1 | Transmit buffer empty |
| txreg_empty_o | output | 1 | Transmit shift register empty |
| rx_full_o | output | 1 | Receive complete |
| rx_perr_o | output | 1 | Parity error on the byte in the receive buffer |
| tx_err_seen_o | output | 1 | Line was low at the middle of the last transmitted stop bit |
| tx_irq_o | output | 1 | Transmit interrupt request |
| tx_irq_clr_i | input | 1 | Clears the transmit interrupt request |
| rx_irq_o | output | 1 | Receive interrupt request |
| rx_irq_clr_i | input | 1 | Clears the receive interrupt request |
| txd_o | output | 1 | Transmit output onto the shared line |
| rxd_i | input | 1 | Shared line level |

## Verification
Flag results appear one cycle after their cause. `txbuf_empty_o` falls the cycle after a write and rises on the same edge that starts the start bit, so the bench samples those flags at the next falling clock edge. Serial results lag their stimulus by a two-flop synchronizer plus up to one oversampling period. For this reason the bench samples line levels at the middle of each bit, half a bit time after the falling edge it detected, which leaves several cycles of margin on both sides. Start-bit width is the one exact timing check, because transmitter transitions always fall on oversampling ticks.

// File: rtl/sc_uart_pkg.sv
package sc_uart_pkg;
  localparam int unsigned DATA_W = 8;
  localparam int unsigned OVS    = 16;
  localparam int unsigned SUB_W  = $clog2(OVS);
  localparam int unsigned IDX_W  = $clog2(DATA_W + 3);

  localparam logic [IDX_W-1:0] IDX_START  = '0;
  localparam logic [IDX_W-1:0] IDX_D_LAST = IDX_W'(DATA_W);
  localparam logic [IDX_W-1:0] IDX_PAR    = IDX_W'(DATA_W + 1);
  localparam logic [IDX_W-1:0] IDX_STOP   = IDX_W'(DATA_W + 2);

  localparam logic [SUB_W-1:0] SUB_MID  = SUB_W'(OVS / 2 - 1);
  localparam logic [SUB_W-1:0] SUB_LAST = SUB_W'(OVS - 1);

  typedef enum logic {
    ST_IDLE,
    ST_BUSY
  } ser_state_e;
endpackage

// File: rtl/sc_uart_baud.sv
module sc_uart_baud #(
  parameter int unsigned DIV_W = 8,
  parameter int unsigned PRE_W = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [1:0]       clk_sel_i,
  input  logic             ext_tick_i,
  input  logic [DIV_W-1:0] div_i,
  output logic             os_tick_o
);
  logic [PRE_W-1:0] pre_q;
  logic [1:0]       ext_sync_q;
  logic             ext_prev_q;
  logic             cnt_tick;
  logic [DIV_W-1:0] dcnt_q;
  logic             os_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pre_q      <= '0;
      ext_sync_q <= '0;
      ext_prev_q <= 1'b0;
    end else begin
      pre_q      <= pre_q + 1'b1;
      ext_sync_q <= {ext_sync_q[0], ext_tick_i};
      ext_prev_q <= ext_sync_q[1];
    end
  end

  always_comb begin
    unique case (clk_sel_i)
      2'd0:    cnt_tick = 1'b1;
      2'd1:    cnt_tick = pre_q[0];
      2'd2:    cnt_tick = &pre_q;
      default: cnt_tick = ext_sync_q[1] & ~ext_prev_q;
    endcase
  end

  // os tick every (div+1) count ticks
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dcnt_q <= '0;
      os_q   <= 1'b0;
    end else begin
      os_q <= 1'b0;
      if (cnt_tick) begin
        if (dcnt_q == '0) begin
          dcnt_q <= div_i;
          os_q   <= 1'b1;
        end else begin
          dcnt_q <= dcnt_q - 1'b1;
        end
      end
    end
  end

  assign os_tick_o = os_q;
endmodule

// File: rtl/sc_uart_tx.sv
module sc_uart_tx
  import sc_uart_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              os_tick_i,
  input  logic              tx_en_i,
  input  logic              par_odd_i,
  input  logic              irq_sel_i,
  input  logic              wr_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic              irq_clr_i,
  input  logic              line_i,
  output logic              buf_empty_o,
  output logic              reg_empty_o,
  output logic              err_seen_o,
  output logic              irq_o,
  output logic              bit_o
);
  ser_state_e        state_q;
  logic [DATA_W-1:0] buf_q, sh_q;
  logic              buf_full_q, par_q, err_q, irq_q;
  logic [SUB_W-1:0]  sub_q;
  logic [IDX_W-1:0]  idx_q;
  logic              load, done;

  assign load = (state_q == ST_IDLE) && buf_full_q && tx_en_i && os_tick_i;
  assign done = (state_q == ST_BUSY) && os_tick_i && (sub_q == SUB_LAST) && (idx_q == IDX_STOP);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      buf_q      <= '0;
      buf_full_q <= 1'b0;
    end else if (wr_i) begin
      buf_q      <= data_i;
      buf_full_q <= 1'b1;
    end else if (load) begin
      buf_full_q <= 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      sub_q   <= '0;
      idx_q   <= '0;
      sh_q    <= '0;
      par_q   <= 1'b0;
      err_q   <= 1'b0;
    end else if (load) begin
      state_q <= ST_BUSY;
      sub_q   <= '0;
      idx_q   <= IDX_START;
      sh_q    <= buf_q;
      par_q   <= (^buf_q) ^ par_odd_i;
    end else if (state_q == ST_BUSY && os_tick_i) begin
      sub_q <= sub_q + 1'b1;
      if (sub_q == SUB_MID && idx_q == IDX_STOP) err_q <= ~line_i;
      if (sub_q == SUB_LAST) begin
        if (idx_q == IDX_STOP) begin
          state_q <= ST_IDLE;
        end else begin
          idx_q <= idx_q + 1'b1;
          if (idx_q != IDX_START && idx_q <= IDX_D_LAST) sh_q <= sh_q >> 1;
        end
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                       irq_q <= 1'b0;
    else if (irq_sel_i ? done : load)  irq_q <= 1'b1;
    else if (irq_clr_i)                irq_q <= 1'b0;
  end

  always_comb begin
    if (state_q == ST_IDLE)        bit_o = 1'b1;
    else if (idx_q == IDX_START)   bit_o = 1'b0;
    else if (idx_q <= IDX_D_LAST)  bit_o = sh_q[0];
    else if (idx_q == IDX_PAR)     bit_o = par_q;
    else                           bit_o = 1'b1;
  end

  assign buf_empty_o = ~buf_full_q;
  assign reg_empty_o = (state_q == ST_IDLE);
  assign err_seen_o  = err_q;
  assign irq_o       = irq_q;
endmodule

// File: rtl/sc_uart_rx.sv
module sc_uart_rx
  import sc_uart_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              os_tick_i,
  input  logic              rx_en_i,
  input  logic              par_odd_i,
  input  logic              line_i,
  input  logic              rd_i,
  input  logic              irq_clr_i,
  output logic [DATA_W-1:0] data_o,
  output logic              full_o,
  output logic              perr_o,
  output logic              irq_o,
  output logic              err_drv_o
);
  ser_state_e        state_q;
  logic [SUB_W-1:0]  sub_q;
  logic [IDX_W-1:0]  idx_q;
  logic [DATA_W-1:0] sh_q, data_q;
  logic              line_prev_q, perr_cur_q, full_q, perr_q, irq_q, drv_q;
  logic              start_det, deliver;

  assign start_det = (state_q == ST_IDLE) && rx_en_i && line_prev_q && !line_i;
  assign deliver   = (state_q == ST_BUSY) && os_tick_i && (sub_q == SUB_MID) && (idx_q == IDX_STOP);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      line_prev_q <= 1'b1;
      state_q     <= ST_IDLE;
      sub_q       <= '0;
      idx_q       <= '0;
      sh_q        <= '0;
      perr_cur_q  <= 1'b0;
      drv_q       <= 1'b0;
    end else begin
      line_prev_q <= line_i;
      if (start_det) begin
        state_q    <= ST_BUSY;
        sub_q      <= '0;
        idx_q      <= IDX_START;
        perr_cur_q <= 1'b0;
      end else if (state_q == ST_BUSY && os_tick_i) begin
        sub_q <= sub_q + 1'b1;
        if (sub_q == SUB_MID) begin
          if (idx_q == IDX_START) begin
            if (line_i) state_q <= ST_IDLE;  // glitch, not a start bit
          end else if (idx_q <= IDX_D_LAST) begin
            sh_q <= {line_i, sh_q[DATA_W-1:1]};
          end else if (idx_q == IDX_PAR) begin
            perr_cur_q <= line_i ^ (^sh_q) ^ par_odd_i;
          end
        end
        if (sub_q == SUB_LAST) begin
          if (idx_q == IDX_STOP) begin
            state_q <= ST_IDLE;
            drv_q   <= 1'b0;
          end else begin
            idx_q <= idx_q + 1'b1;
            if (idx_q == IDX_PAR && perr_cur_q) drv_q <= 1'b1;
          end
        end
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      data_q <= '0;
      perr_q <= 1'b0;
      full_q <= 1'b0;
      irq_q  <= 1'b0;
    end else begin
      if (deliver) begin
        data_q <= sh_q;
        perr_q <= perr_cur_q;
      end
      if (deliver)        full_q <= 1'b1;
      else if (rd_i)      full_q <= 1'b0;
      if (deliver)        irq_q  <= 1'b1;
      else if (irq_clr_i) irq_q  <= 1'b0;
    end
  end

  assign data_o    = data_q;
  assign full_o    = full_q;
  assign perr_o    = perr_q;
  assign irq_o     = irq_q;
  assign err_drv_o = drv_q;
endmodule

// File: rtl/sc_uart.sv
module sc_uart
  import sc_uart_pkg::*;
#(
  parameter int unsigned DIV_W = 8,
  parameter int unsigned PRE_W = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [1:0]        clk_sel_i,
  input  logic              ext_tick_i,
  input  logic [DIV_W-1:0]  div_i,
  input  logic              tx_en_i,
  input  logic              rx_en_i,
  input  logic              par_odd_i,
  input  logic              tx_irq_sel_i,
  input  logic              tx_wr_i,
  input  logic [DATA_W-1:0] tx_data_i,
  input  logic              rx_rd_i,
  output logic [DATA_W-1:0] rx_data_o,
  output logic              txbuf_empty_o,
  output logic              txreg_empty_o,
  output logic              rx_full_o,
  output logic              rx_perr_o,
  output logic              tx_err_seen_o,
  output logic              tx_irq_o,
  input  logic              tx_irq_clr_i,
  output logic              rx_irq_o,
  input  logic              rx_irq_clr_i,
  output logic              txd_o,
  input  logic              rxd_i
);
  logic [1:0] line_sync_q;
  logic       line_s, os_tick, tx_bit, rx_err_drv;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) line_sync_q <= 2'b11;
    else         line_sync_q <= {line_sync_q[0], rxd_i};
  end
  assign line_s = line_sync_q[1];

  sc_uart_baud #(.DIV_W(DIV_W), .PRE_W(PRE_W)) u_baud (
    .clk_i, .rst_ni, .clk_sel_i, .ext_tick_i, .div_i,
    .os_tick_o(os_tick)
  );

  sc_uart_tx u_tx (
    .clk_i, .rst_ni,
    .os_tick_i  (os_tick),
    .tx_en_i,
    .par_odd_i,
    .irq_sel_i  (tx_irq_sel_i),
    .wr_i       (tx_wr_i),
    .data_i     (tx_data_i),
    .irq_clr_i  (tx_irq_clr_i),
    .line_i     (line_s),
    .buf_empty_o(txbuf_empty_o),
    .reg_empty_o(txreg_empty_o),
    .err_seen_o (tx_err_seen_o),
    .irq_o      (tx_irq_o),
    .bit_o      (tx_bit)
  );

  sc_uart_rx u_rx (
    .clk_i, .rst_ni,
    .os_tick_i(os_tick),
    .rx_en_i,
    .par_odd_i,
    .line_i   (line_s),
    .rd_i     (rx_rd_i),
    .irq_clr_i(rx_irq_clr_i),
    .data_o   (rx_data_o),
    .full_o   (rx_full_o),
    .perr_o   (rx_perr_o),
    .irq_o    (rx_irq_o),
    .err_drv_o(rx_err_drv)
  );

  // error pulse overrides the transmit bit on the shared line
  assign txd_o = tx_bit & ~rx_err_drv;
endmodule

// File: rtl/sc_uart_chk.sv
module sc_uart_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic tx_wr_i,
  input logic tx_en_i,
  input logic txbuf_empty_o,
  input logic txreg_empty_o,
  input logic tx_irq_o,
  input logic tx_irq_clr_i,
  input logic rx_irq_o,
  input logic rx_irq_clr_i,
  input logic rx_full_o,
  input logic rx_rd_i,
  input logic txd_o,
  input logic rx_err_drv_i
);
  a_r5_wr_clears_empty: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_wr_i |=> !txbuf_empty_o);

  a_r6_idle_line_high: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (txreg_empty_o && !rx_err_drv_i) |-> txd_o);

  a_r8_tx_irq_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tx_irq_o && !tx_irq_clr_i) |=> tx_irq_o);

  a_r8_rx_irq_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rx_irq_o && !rx_irq_clr_i) |=> rx_irq_o);

  a_r9_no_start_disabled: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!tx_en_i && txreg_empty_o) |=> txreg_empty_o);

  a_r10_full_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rx_full_o && !rx_rd_i) |=> rx_full_o);
endmodule

bind sc_uart sc_uart_chk u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .tx_wr_i      (tx_wr_i),
  .tx_en_i      (tx_en_i),
  .txbuf_empty_o(txbuf_empty_o),
  .txreg_empty_o(txreg_empty_o),
  .tx_irq_o     (tx_irq_o),
  .tx_irq_clr_i (tx_irq_clr_i),
  .rx_irq_o     (rx_irq_o),
  .rx_irq_clr_i (rx_irq_clr_i),
  .rx_full_o    (rx_full_o),
  .rx_rd_i      (rx_rd_i),
  .txd_o        (txd_o),
  .rx_err_drv_i (rx_err_drv)
);

// File: tb/sc_uart_test.sv
`timescale 1ns/1ps
module sc_uart_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] clk_sel = 2'd0;
  logic       ext_tick = 1'b0;
  logic [7:0] div = 8'd1;
  logic       tx_en = 1'b0, rx_en = 1'b0, par_odd = 1'b0, irq_sel = 1'b0;
  logic       tx_wr = 1'b0, rx_rd = 1'b0, tx_clr = 1'b0, rx_clr = 1'b0;
  logic [7:0] tx_data = 8'h00;
  logic [7:0] rx_data;
  logic       txbuf_empty, txreg_empty, rx_full, rx_perr, err_seen;
  logic       tx_irq, rx_irq, txd;
  logic       peer_drv = 1'b1;
  logic       line;

  int checks = 0;
  int errors = 0;
  int bit_clks = 32;
  int tx_frames = 0;
  int rx_frames = 0;
  logic [7:0] txq[$];
  logic [8:0] rxq[$];

  always #2 clk = ~clk;
  assign line = txd & peer_drv;

  sc_uart uut (
    .clk_i(clk), .rst_ni(rst_n), .clk_sel_i(clk_sel), .ext_tick_i(ext_tick),
    .div_i(div), .tx_en_i(tx_en), .rx_en_i(rx_en), .par_odd_i(par_odd),
    .tx_irq_sel_i(irq_sel), .tx_wr_i(tx_wr), .tx_data_i(tx_data), .rx_rd_i(rx_rd),
    .rx_data_o(rx_data), .txbuf_empty_o(txbuf_empty), .txreg_empty_o(txreg_empty),
    .rx_full_o(rx_full), .rx_perr_o(rx_perr), .tx_err_seen_o(err_seen),
    .tx_irq_o(tx_irq), .tx_irq_clr_i(tx_clr), .rx_irq_o(rx_irq), .rx_irq_clr_i(rx_clr),
    .txd_o(txd), .rxd_i(line)
  );

  task automatic check(input logic ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  task automatic wait_clks(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic write_tx(input logic [7:0] d);
    @(negedge clk);
    tx_data = d;
    tx_wr   = 1'b1;
    @(negedge clk);
    tx_wr   = 1'b0;
  endtask

  task automatic wait_tx_idle();
    @(negedge clk);
    while (!(txbuf_empty && txreg_empty)) @(negedge clk);
  endtask

  // serial peer driving the shared line
  task automatic send_frame(input logic [7:0] d, input logic bad, input logic expect_rx);
    logic p;
    p = (^d) ^ par_odd ^ bad;
    if (expect_rx) rxq.push_back({bad, d});
    @(negedge clk);
    peer_drv = 1'b0;
    wait_clks(bit_clks);
    for (int k = 0; k < 8; k++) begin
      peer_drv = d[k];
      wait_clks(bit_clks);
    end
    peer_drv = p;
    wait_clks(bit_clks / 2);
    check(txd == 1'b1, "R12 no pulse before stop", txd, 1);
    wait_clks(bit_clks - bit_clks / 2);
    peer_drv = 1'b1;
    wait_clks(bit_clks / 2);
    check(txd == !(bad && expect_rx), "R12 stop slot level", txd, !(bad && expect_rx));
    wait_clks(bit_clks - bit_clks / 2 + bit_clks / 2);
    check(txd == 1'b1, "R12 pulse released", txd, 1);
    wait_clks(bit_clks);
  endtask

  // tx monitor: decode frames at mid-bit and compare against the scoreboard
  initial begin
    forever begin
      @(negedge clk);
      if (rst_n && txd == 1'b0 && !txreg_empty) begin
        int bt;
        logic [7:0] d;
        logic p, s, exp_p;
        logic [7:0] e;
        bt = bit_clks;
        wait_clks(bt / 2 - 1);
        check(txd == 1'b0, "R2 start bit", txd, 0);
        for (int k = 0; k < 8; k++) begin
          wait_clks(bt);
          d[k] = txd;
        end
        wait_clks(bt);
        p = txd;
        wait_clks(bt);
        s = txd;
        tx_frames++;
        if (txq.size() == 0) begin
          check(1'b0, "R2 unexpected frame", d, 0);
        end else begin
          e = txq.pop_front();
          exp_p = (^e) ^ par_odd;
          check(d == e, "R2 data", d, e);
          check(p == exp_p, "R3 parity", p, exp_p);
          check(s == 1'b1, "R2 stop bit", s, 1);
        end
      end
    end
  end

  // rx monitor
  initial begin
    forever begin
      @(negedge clk);
      if (rst_n && rx_full) begin
        logic [8:0] e;
        rx_frames++;
        check(rx_irq == 1'b1, "R10 rx irq", rx_irq, 1);
        if (rxq.size() == 0) begin
          check(1'b0, "R11 unexpected rx", rx_data, 0);
        end else begin
          e = rxq.pop_front();
          check(rx_data == e[7:0], "R10 rx data", rx_data, e[7:0]);
          check(rx_perr == e[8], "R12 rx_perr", rx_perr, e[8]);
        end
        rx_rd  = 1'b1;
        rx_clr = 1'b1;
        @(negedge clk);
        rx_rd  = 1'b0;
        rx_clr = 1'b0;
        @(negedge clk);
        check(rx_full == 1'b0, "R10 read clears full", rx_full, 0);
        check(rx_irq == 1'b0, "R8 rx irq clear", rx_irq, 0);
      end
    end
  end

  initial begin
    wait_clks(200000);
    check(1'b0, "watchdog", 0, 1);
    finish_run();
  end

  initial begin
    int w;
    wait_clks(5);
    rst_n = 1'b1;
    @(negedge clk);
    // R1
    check(txd == 1'b1, "R1 txd", txd, 1);
    check(txbuf_empty && txreg_empty, "R1 tx empties", {txbuf_empty, txreg_empty}, 3);
    check(!rx_full && !rx_perr && !err_seen, "R1 rx/err flags", {rx_full, rx_perr, err_seen}, 0);
    check(!tx_irq && !rx_irq, "R1 irqs", {tx_irq, rx_irq}, 0);

    tx_en = 1'b1;
    // R4/R5/R6/R7 with irq on buffer transfer
    txq.push_back(8'h01);
    write_tx(8'h01);
    check(txbuf_empty == 1'b0, "R5 write clears empty", txbuf_empty, 0);
    while (!txbuf_empty) @(negedge clk);
    check(txd == 1'b0, "R5 start with transfer", txd, 0);
    check(tx_irq == 1'b1, "R7 irq on transfer", tx_irq, 1);
    check(txreg_empty == 1'b0, "R6 reg busy", txreg_empty, 0);
    w = 0;
    while (txd == 1'b0) begin
      w++;
      @(negedge clk);
    end
    check(w == 32, "R4 bit time div1", w, 32);
    wait_tx_idle();
    check(txreg_empty == 1'b1, "R6 reg empty after frame", txreg_empty, 1);
    wait_clks(20);
    check(tx_irq == 1'b1, "R8 tx irq held", tx_irq, 1);
    tx_clr = 1'b1;
    @(negedge clk);
    tx_clr = 1'b0;
    @(negedge clk);
    check(tx_irq == 1'b0, "R8 tx irq cleared", tx_irq, 0);

    // back to back, double buffering
    txq.push_back(8'h3C);
    txq.push_back(8'hFF);
    write_tx(8'h3C);
    wait_clks(4);
    write_tx(8'hFF);
    check(txbuf_empty == 1'b0 && txreg_empty == 1'b0, "R5 second byte buffered",
          {txbuf_empty, txreg_empty}, 0);
    wait_tx_idle();
    tx_clr = 1'b1;
    @(negedge clk);
    tx_clr = 1'b0;

    // odd parity, irq on completion
    par_odd = 1'b1;
    irq_sel = 1'b1;
    txq.push_back(8'h00);
    write_tx(8'h00);
    while (!txbuf_empty) @(negedge clk);
    check(tx_irq == 1'b0, "R7 no irq on transfer when sel=1", tx_irq, 0);
    while (!txreg_empty) @(negedge clk);
    check(tx_irq == 1'b1, "R7 irq on completion", tx_irq, 1);
    tx_clr = 1'b1;
    @(negedge clk);
    tx_clr = 1'b0;
    txq.push_back(8'h7E);
    write_tx(8'h7E);
    wait_tx_idle();
    par_odd = 1'b0;
    irq_sel = 1'b0;

    // R9 transmit disabled
    tx_en = 1'b0;
    write_tx(8'h5A);
    w = tx_frames;
    wait_clks(3 * bit_clks);
    check(txreg_empty == 1'b1 && txd == 1'b1, "R9 no start while disabled", {txreg_empty, txd}, 3);
    check(txbuf_empty == 1'b0, "R9 byte held", txbuf_empty, 0);
    txq.push_back(8'h5A);
    tx_en = 1'b1;
    wait_tx_idle();
    wait_clks(4);
    check(tx_frames == w + 1, "R9 sent after enable", tx_frames, w + 1);

    // R4 prescaler /2 with div 2
    clk_sel  = 2'd1;
    div      = 8'd2;
    bit_clks = 96;
    wait_clks(20);
    txq.push_back(8'h81);
    write_tx(8'h81);
    while (txd == 1'b1) @(negedge clk);
    w = 0;
    while (txd == 1'b0) begin
      w++;
      @(negedge clk);
    end
    check(w == 96, "R4 bit time sel1 div2", w, 96);
    wait_tx_idle();
    clk_sel  = 2'd0;
    div      = 8'd1;
    bit_clks = 32;
    wait_clks(20);

    // R13 far end signals error in our stop slot
    txq.push_back(8'h96);
    write_tx(8'h96);
    while (txd == 1'b1) @(negedge clk);
    wait_clks(10 * bit_clks + 2);
    peer_drv = 1'b0;
    wait_clks(bit_clks - 6);
    peer_drv = 1'b1;
    wait_tx_idle();
    check(err_seen == 1'b1, "R13 error seen", err_seen, 1);
    txq.push_back(8'h11);
    write_tx(8'h11);
    wait_tx_idle();
    check(err_seen == 1'b0, "R13 clean stop", err_seen, 0);

    // receive path
    wait_clks(2 * bit_clks);
    rx_en = 1'b1;
    send_frame(8'hC3, 1'b0, 1'b1);
    send_frame(8'h5A, 1'b1, 1'b1);
    par_odd = 1'b1;
    send_frame(8'h00, 1'b0, 1'b1);
    par_odd = 1'b0;
    wait_clks(bit_clks);
    // R11 receive disabled
    rx_en = 1'b0;
    w = rx_frames;
    send_frame(8'h77, 1'b1, 1'b0);
    wait_clks(2 * bit_clks);
    check(rx_full == 1'b0 && rx_frames == w, "R11 ignored while disabled", rx_full, 0);

    wait_clks(2 * bit_clks);
    check(txq.size() == 0, "R2 all tx frames seen", txq.size(), 0);
    check(rxq.size() == 0, "R10 all rx frames seen", rxq.size(), 0);
    finish_run();
  end
endmodule